// File: doc/BRIEF.md
# Sticky Equal-Run Detector

This block watches two single-bit streams that arrive together, one bit of each per clock. It counts how many cycles in a row the two bits have held the same value. When that count reaches the run length (five by default), a terminal state latches and the output flag stays high from then on. The output is a Moore output: it is decoded from the state alone. It therefore goes high one cycle after the last pair of the qualifying run has been clocked in.

The stored state needs no initialization at power-up. An input called `start` forces every state bit to zero before that state reaches the decode and next-state logic. The all-zero pattern is the idle encoding, so while `start` is high the machine behaves exactly as if it were idle. Its flag reads low, and its next state is computed from idle together with the pair present in that cycle. A synchronous active-high reset also clears the register.

The state register holds a binary run count from 0 to RUN_LEN-1. The value RUN_LEN marks the detected state.

Top module: `equal_run_detect`

## Requirements
- R1: A cycle counts toward the run whenever `x_in` equals `y_in`, so the pairs 00 and 11 both extend the run.
- R2: A cycle with `x_in` different from `y_in` (pair 01 or 10) returns the run count to zero, unless detection has already occurred.
- R3: `z_out` goes to 1 in the cycle after the fifth consecutive equal pair is clocked in (RUN_LEN = 5). A run of only four equal pairs followed by an unequal pair leaves `z_out` at 0.
- R4: Once detection has occurred, `z_out` stays 1 on every later cycle with `start` low, whatever pairs follow.
- R5: While `start` is 1, `z_out` reads 0.
- R6: While `start` is 1, the next state is computed from the idle state and the current pair. An equal pair makes the run length 1, and an unequal pair leaves the machine idle. This clears an earlier detection.
- R7: With `start` at 0, the machine follows its stored state with no masking.
- R8: A clock edge with `rst` at 1 puts the machine in the idle state. After `rst` is released, `z_out` reads 0 and the run count starts again from zero.
- R9: Applying x = 00101001010010101110 and y = 01101111010001101111 left to right, one pair per cycle after reset, yields z = 00000000000011111111. Each z bit is read in the same cycle as the pair at that position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Masks the stored state to the idle encoding while high |
| x_in | input | 1 | First stream bit |
| y_in | input | 1 | Second stream bit |
| z_out | output | 1 | Sticky detection flag (Moore) |

## Verification
The pair stream is built from several kinds of run:
- runs made only of 00 and only of 11, which show that both equal values count;
- mixed runs of exactly four equal pairs broken by 01 or 10, which separate a near miss from a hit;
- runs of five, which must trigger;
- long unequal tails after a detection, which show the flag is sticky.

Pulses on `start` are placed in three positions:
- mid-run, where the count must restart at one rather than continue;
- after a detection, where the flag must drop and stay cleared if an unequal pair was present under the pulse;
- combined with an equal pair, which must count as the first of a new run.

A reset mid-run shows that the count is discarded. The twenty-pair example stream checks the exact cycle at which the flag rises.

// File: rtl/equal_run_pkg.sv
package equal_run_pkg;

   // Bits needed to encode run lengths 0..run_len (terminal state included)
   function automatic int state_bits(input int run_len);
      int w;
      w = $clog2(run_len + 1);
      if (w < 1) w = 1;
      return w;
   endfunction

endpackage

// File: rtl/pair_match.sv
module pair_match (
   input  logic a_bit,
   input  logic b_bit,
   output logic same
);
   always_comb same = ~(a_bit ^ b_bit);
endmodule

// File: rtl/state_gate.sv
module state_gate #(
   parameter int SW = 3
) (
   input  logic          kill,
   input  logic [SW-1:0] q_raw,
   output logic [SW-1:0] q_eff
);
   genvar i;
   generate
      for (i = 0; i < SW; i++) begin : g_bit
         assign q_eff[i] = q_raw[i] & ~kill;
      end
   endgenerate
endmodule

// File: rtl/run_next.sv
module run_next #(
   parameter int RUN_LEN = 5,
   parameter int SW      = 3
) (
   input  logic [SW-1:0] cur,
   input  logic          same,
   output logic [SW-1:0] nxt,
   output logic          hit
);
   localparam logic [SW-1:0] DONE = SW'(RUN_LEN);
   localparam logic [SW-1:0] ONE  = SW'(1);

   always_comb begin
      hit = (cur == DONE);
      if (hit)       nxt = DONE;
      else if (same) nxt = cur + ONE;
      else           nxt = '0;
   end
endmodule

// File: rtl/equal_run_detect.sv
module equal_run_detect #(
   parameter int RUN_LEN = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic x_in,
   input  logic y_in,
   output logic z_out
);
   localparam int SW = equal_run_pkg::state_bits(RUN_LEN);

   generate
      if (RUN_LEN < 1) begin : g_bad_len
         $error("RUN_LEN must be at least 1");
      end
   endgenerate

   logic [SW-1:0] state_q;
   logic [SW-1:0] state_m;
   logic [SW-1:0] state_d;
   logic          same;

   pair_match u_match (
      .a_bit (x_in),
      .b_bit (y_in),
      .same  (same)
   );

   state_gate #(.SW(SW)) u_gate (
      .kill  (start),
      .q_raw (state_q),
      .q_eff (state_m)
   );

   run_next #(.RUN_LEN(RUN_LEN), .SW(SW)) u_next (
      .cur  (state_m),
      .same (same),
      .nxt  (state_d),
      .hit  (z_out)
   );

   always_ff @(posedge clk) begin
      if (rst) state_q <= '0;
      else     state_q <= state_d;
   end
endmodule

// File: rtl/equal_run_detect_chk.sv
module equal_run_detect_chk #(
   parameter int RUN_LEN = 5,
   parameter int SW      = 3
) (
   input logic          clk,
   input logic          rst,
   input logic          start,
   input logic          x_in,
   input logic          y_in,
   input logic          z_out,
   input logic [SW-1:0] state_q
);
   // R4
   sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
      z_out |=> (z_out || start));

   // R5
   start_blanks_chk: assert property (@(posedge clk) disable iff (rst)
      start |-> !z_out);

   // R2
   mismatch_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (!start && !z_out && (x_in != y_in)) |=> (state_q == '0));

   // R3
   rise_after_equal_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(z_out) |-> $past(x_in == y_in));

   // R6
   start_restart_chk: assert property (@(posedge clk) disable iff (rst)
      (start && (x_in == y_in)) |=> (state_q == SW'(1)));

   // R8
   reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (state_q == '0));
endmodule

bind equal_run_detect equal_run_detect_chk #(.RUN_LEN(RUN_LEN), .SW(SW)) chk_i (
   .clk     (clk),
   .rst     (rst),
   .start   (start),
   .x_in    (x_in),
   .y_in    (y_in),
   .z_out   (z_out),
   .state_q (state_q)
);

// File: tb/equal_run_detect_tb_top.sv
module equal_run_detect_tb_top;
   localparam int RUN = 5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic x_in = 1'b0;
   logic y_in = 1'b0;
   logic z_out;

   int compared = 0;
   int mismatched = 0;
   int ref_cnt = 0;
   bit finished = 1'b0;

   bit    exp_q[$];
   string tag_q[$];

   always #4 clk = ~clk;

   equal_run_detect #(.RUN_LEN(RUN)) dut_i (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .x_in  (x_in),
      .y_in  (y_in),
      .z_out (z_out)
   );

   // Driver: apply one pair, predict z for this cycle, advance reference
   task automatic step(input bit xv, input bit yv, input bit sv, input string tag);
      int base;
      @(negedge clk);
      rst   = 1'b0;
      x_in  = xv;
      y_in  = yv;
      start = sv;
      exp_q.push_back(sv ? 1'b0 : (ref_cnt == RUN));
      tag_q.push_back(tag);
      base = sv ? 0 : ref_cnt;
      if (base >= RUN)   ref_cnt = RUN;
      else if (xv == yv) ref_cnt = base + 1;
      else               ref_cnt = 0;
   endtask

   task automatic do_reset(input int cycles);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         rst = 1'b1;
         start = 1'b0;
      end
      ref_cnt = 0;
   endtask

   task automatic run_strings(input string xs, input string ys, input string tag);
      for (int i = 0; i < xs.len(); i++)
         step(xs[i] == "1", ys[i] == "1", 1'b0, tag);
   endtask

   // Monitor: compare away from the rising edge
   always @(negedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         bit    e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         compared++;
         if (z_out !== e) begin
            mismatched++;
            $display("FAIL %s: z_out=%0b expected %0b at %0t", t, z_out, e, $time);
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         mismatched++;
         compared++;
         $display("FAIL watchdog: run did not finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      do_reset(3);
      step(0, 0, 0, "R8 reset state");

      // R9 example stream
      do_reset(2);
      run_strings("00101001010010101110", "01101111010001101111", "R9 example");

      // R1 only 00 pairs, then only 11 pairs
      do_reset(2);
      for (int i = 0; i < 7; i++) step(0, 0, 0, "R1 zeros run");
      do_reset(2);
      for (int i = 0; i < 7; i++) step(1, 1, 0, "R1 ones run");

      // R3 four equal then break, twice; R2 break values 01 and 10
      do_reset(2);
      step(0, 0, 0, "R3 near miss"); step(1, 1, 0, "R3 near miss");
      step(1, 1, 0, "R3 near miss"); step(0, 0, 0, "R3 near miss");
      step(0, 1, 0, "R2 break 01");
      step(1, 1, 0, "R3 near miss"); step(0, 0, 0, "R3 near miss");
      step(0, 0, 0, "R3 near miss"); step(1, 1, 0, "R3 near miss");
      step(1, 0, 0, "R2 break 10");
      // R3 exactly five triggers
      for (int i = 0; i < 5; i++) step(i[0], i[0], 0, "R3 run of five");
      // R4 sticky under unequal pairs
      for (int i = 0; i < 6; i++) step(i[0], !i[0], 0, "R4 sticky");
      step(1, 1, 0, "R4 sticky");

      // R5 start after detection; R6 unequal under start clears detection
      step(0, 1, 1, "R5 start blanks z");
      step(0, 1, 0, "R6 cleared after start");
      step(1, 1, 0, "R7 normal count");

      // R6 start mid-run with an equal pair restarts count at one
      do_reset(2);
      step(0, 0, 0, "R6 pre-run"); step(1, 1, 0, "R6 pre-run"); step(0, 0, 0, "R6 pre-run");
      step(1, 1, 1, "R5 start mid-run");
      for (int i = 0; i < 5; i++) step(0, 0, 0, "R6 restart at one");

      // R5/R6 start held with detection present, equal pair
      step(1, 1, 1, "R5 start held");
      step(1, 1, 1, "R5 start held");
      for (int i = 0; i < 5; i++) step(1, 1, 0, "R6 count after start");

      // R8 reset mid-run discards count
      do_reset(2);
      for (int i = 0; i < 4; i++) step(1, 1, 0, "R8 pre-reset run");
      do_reset(1);
      step(0, 0, 0, "R8 count restarted");
      step(0, 0, 0, "R8 count restarted");

      repeat (3) @(negedge clk);
      #3;
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule